// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Tick

This block is a timer peripheral. It has three parts. The first is a free-running real-time counter made of a narrow upper part and a wide lower word, 40 bits by default. The second is a comparator that flags when that counter reaches a programmed target. The third is a reloadable down-counter that produces a steady tick. All three advance only on cycles where the timer clock enable is high. Software sees a small register file through a single-cycle write port and a combinational read port.

A control register freezes each part on its own. Freezing the lower word also stops carries into the upper part. A clear bit holds the counter at zero for as long as it is set. Another bit enables the periodic timer. Three sticky status flags record counter rollover, alarm match and periodic expiry. Each flag drives its own interrupt output, and software clears a flag by writing 1 to it. Reads of the upper and lower words are two separate accesses, so software that needs a consistent pair reads twice and compares.

Top module: `rtc_alarm_timer`

## Requirements
- R1: The counter value is {upper, lower}. Upper is HI_W bits (default 8) and reads in bits [HI_W-1:0] of address 1. Lower is LO_W bits (default 32) and reads at address 2. The lower word increments by one per enabled tick. The upper part increments when the lower word wraps from all ones.
- R2: Control bits at address 0 are bit 0 = freeze upper, bit 1 = freeze lower, bit 2 = freeze periodic. A frozen part holds its value, and a frozen lower word produces no carry.
- R3: While control bit 3 is 1, both counter parts are forced to zero one cycle later. After bit 3 returns to 0, the counter reads 0 in the first cycle and 1 in the next.
- R4: Control bit 4 enables the periodic timer. While it is 0, the down-counter is preloaded with the period register (address 5). After reset, control, period, alarm target and status all read 0, and the counter starts from zero.
- R5: With period P and the enable set, the first periodic expiry flag appears P+1 ticks after the enable takes effect. Later expiries follow every P+1 ticks.
- R6: A write to the period register while the timer runs leaves the countdown in progress unchanged. The new value is used from the next reload.
- R7: The alarm target upper part is written at address 3, keeping only its low HI_W bits, and reads back masked. The lower word is written at address 4. The alarm flag sets on the tick where the counter steps onto the target.
- R8: The rollover flag sets on the tick where the full counter wraps from all ones to zero.
- R9: Status at address 6 holds rollover in bit 31, alarm in bit 30 and periodic in bit 29. irq_roll, irq_alarm and irq_period mirror these bits. Writing 1 to a bit clears it. If an event occurs in the same cycle as its clear, the event wins and the bit stays set.
- R10: While tick_en is 0, neither counter part changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable: one tick per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq_roll | output | 1 | Rollover status |
| irq_alarm | output | 1 | Alarm status |
| irq_period | output | 1 | Periodic expiry status |

## Verification
The periodic timer is driven from a table of period values, from 0 up to 12. Each entry checks the exact cycle of the first expiry, which separates a P+1 interval from an off-by-one P or P+2. Directed runs then cover the counter under these conditions, and each result separates holding from counting:
- free running
- each freeze bit on its own
- tick_en held low
- clear held and released

The bench uses narrow counter widths, so it can see a full wrap and a carry into the upper part. It checks the alarm one cycle before the target and on the target. Period 0 causes an expiry on every tick, which is used to show that an event in the same cycle as a write-one clear keeps its status bit set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_CNT_HI = 1;
   localparam int unsigned REG_CNT_LO = 2;
   localparam int unsigned REG_ALM_HI = 3;
   localparam int unsigned REG_ALM_LO = 4;
   localparam int unsigned REG_PERIOD = 5;
   localparam int unsigned REG_STATUS = 6;

   localparam int unsigned CTRL_W     = 5;

   localparam int unsigned ST_PER     = 29;
   localparam int unsigned ST_ALARM   = 30;
   localparam int unsigned ST_ROLL    = 31;
   localparam int unsigned ST_NUM     = 3;

   typedef struct packed {
      logic per_en;
      logic clr;
      logic frz_per;
      logic frz_lo;
      logic frz_hi;
   } ctrl_t;

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
   import rtc_pkg::*;
#(
   parameter int unsigned HI_W = 8,
   parameter int unsigned LO_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick_en,
   input  ctrl_t                  ctrl,
   output logic [HI_W-1:0]        cnt_hi,
   output logic [LO_W-1:0]        cnt_lo,
   output logic [HI_W+LO_W-1:0]   cnt_nxt,
   output logic                   adv,
   output logic                   roll_evt
);

   localparam int unsigned FULL_W = HI_W + LO_W;

   logic            lo_carry;
   logic            hi_step;
   logic [HI_W-1:0] hi_nxt;
   logic [LO_W-1:0] lo_nxt;

   always_comb begin
      adv      = tick_en & ~ctrl.frz_lo & ~ctrl.clr;
      lo_carry = adv & (&cnt_lo);
      hi_step  = lo_carry & ~ctrl.frz_hi;
      roll_evt = hi_step & (&cnt_hi);
      if (ctrl.clr) begin
         lo_nxt = '0;
         hi_nxt = '0;
      end else begin
         lo_nxt = adv     ? cnt_lo + 1'b1 : cnt_lo;
         hi_nxt = hi_step ? cnt_hi + 1'b1 : cnt_hi;
      end
      cnt_nxt = {hi_nxt, lo_nxt};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         cnt_lo <= lo_nxt;
         cnt_hi <= hi_nxt;
      end
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.clr |=> ({cnt_hi, cnt_lo} == {FULL_W{1'b0}}));                 // R3
   AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.frz_lo && !ctrl.clr) |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R2
   AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.frz_hi && !ctrl.clr) |=> $stable(cnt_hi));                    // R2
   AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !ctrl.clr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));  // R10
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      roll_evt |=> ({cnt_hi, cnt_lo} == {FULL_W{1'b0}}));                 // R8

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int unsigned HI_W   = 8,
   parameter int unsigned LO_W   = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_hi,
   input  logic                   wr_lo,
   input  logic [DATA_W-1:0]      wdata,
   input  logic                   adv,
   input  logic [HI_W+LO_W-1:0]   cnt_nxt,
   output logic [HI_W-1:0]        tgt_hi,
   output logic [LO_W-1:0]        tgt_lo,
   output logic                   hit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_hi <= '0;
         tgt_lo <= '0;
      end else begin
         if (wr_hi) tgt_hi <= wdata[HI_W-1:0];
         if (wr_lo) tgt_lo <= wdata[LO_W-1:0];
      end
   end

   assign hit = adv & (cnt_nxt == {tgt_hi, tgt_lo});

   AST_ALM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |-> !hit);                                                     // R7

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
   parameter int unsigned PER_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             en,
   input  logic             frz,
   input  logic [PER_W-1:0] per_val,
   output logic             expire
);

   logic [PER_W-1:0] down_q;
   logic             run;

   assign run    = tick_en & en & ~frz;
   assign expire = run & (down_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         down_q <= '0;
      end else if (!en) begin
         down_q <= per_val;
      end else if (run) begin
         if (down_q == '0) down_q <= per_val;
         else              down_q <= down_q - 1'b1;
      end
   end

   AST_PER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (down_q == $past(per_val)));                             // R6
   AST_PER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (down_q == $past(per_val)));                                // R4
   AST_PER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && frz) |=> $stable(down_q));                                   // R2
   AST_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && down_q != '0) |=> (down_q == $past(down_q) - 1'b1));        // R5

endmodule

// File: rtl/rtc_status.sv
module rtc_status #(
   parameter int unsigned NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set,
   input  logic [NUM-1:0] clr,
   output logic [NUM-1:0] st
);

   for (genvar i = 0; i < NUM; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      st[i] <= 1'b0;
         else if (set[i]) st[i] <= 1'b1;
         else if (clr[i]) st[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> st[i]);                                               // R9
      AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !st[i]);                                 // R9
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (st[i] && !clr[i]) |=> st[i]);                                   // R9
   end

endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
   import rtc_pkg::*;
#(
   parameter int unsigned HI_W   = 8,
   parameter int unsigned LO_W   = 32,
   parameter int unsigned PER_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_roll,
   output logic              irq_alarm,
   output logic              irq_period
);

   localparam int unsigned FULL_W = HI_W + LO_W;

   if (DATA_W < 32) begin : g_chk_data
      $error("DATA_W must hold status bits 31..29");
   end
   if (LO_W > DATA_W || HI_W > DATA_W || PER_W > DATA_W) begin : g_chk_fit
      $error("counter, alarm and period fields must fit in DATA_W");
   end
   if (HI_W < 1 || LO_W < 2 || PER_W < 1) begin : g_chk_min
      $error("field widths too small");
   end
   if ((1 << ADDR_W) <= REG_STATUS) begin : g_chk_addr
      $error("ADDR_W too narrow for the register map");
   end

   ctrl_t             ctrl_q;
   logic [PER_W-1:0]  per_q;
   logic [HI_W-1:0]   cnt_hi;
   logic [LO_W-1:0]   cnt_lo;
   logic [FULL_W-1:0] cnt_nxt;
   logic [HI_W-1:0]   tgt_hi;
   logic [LO_W-1:0]   tgt_lo;
   logic              adv, roll_evt, alm_hit, per_exp;
   logic [ST_NUM-1:0] st_set, st_clr, st_q;

   logic wr_ctrl, wr_ahi, wr_alo, wr_per, wr_stat;

   always_comb begin
      wr_ctrl = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
      wr_ahi  = reg_wr && (reg_addr == ADDR_W'(REG_ALM_HI));
      wr_alo  = reg_wr && (reg_addr == ADDR_W'(REG_ALM_LO));
      wr_per  = reg_wr && (reg_addr == ADDR_W'(REG_PERIOD));
      wr_stat = reg_wr && (reg_addr == ADDR_W'(REG_STATUS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         per_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (wr_per)  per_q  <= reg_wdata[PER_W-1:0];
      end
   end

   rtc_counter #(.HI_W(HI_W), .LO_W(LO_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .ctrl    (ctrl_q),
      .cnt_hi  (cnt_hi),
      .cnt_lo  (cnt_lo),
      .cnt_nxt (cnt_nxt),
      .adv     (adv),
      .roll_evt(roll_evt)
   );

   rtc_alarm #(.HI_W(HI_W), .LO_W(LO_W), .DATA_W(DATA_W)) u_alm (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hi  (wr_ahi),
      .wr_lo  (wr_alo),
      .wdata  (reg_wdata),
      .adv    (adv),
      .cnt_nxt(cnt_nxt),
      .tgt_hi (tgt_hi),
      .tgt_lo (tgt_lo),
      .hit    (alm_hit)
   );

   rtc_periodic #(.PER_W(PER_W)) u_per (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_en(tick_en),
      .en     (ctrl_q.per_en),
      .frz    (ctrl_q.frz_per),
      .per_val(per_q),
      .expire (per_exp)
   );

   assign st_set = {roll_evt, alm_hit, per_exp};
   assign st_clr = wr_stat ? reg_wdata[ST_ROLL:ST_PER] : '0;

   rtc_status #(.NUM(ST_NUM)) u_st (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (st_set),
      .clr  (st_clr),
      .st   (st_q)
   );

   assign irq_roll   = st_q[2];
   assign irq_alarm  = st_q[1];
   assign irq_period = st_q[0];

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(REG_CTRL):   reg_rdata[CTRL_W-1:0]    = ctrl_q;
         ADDR_W'(REG_CNT_HI): reg_rdata[HI_W-1:0]      = cnt_hi;
         ADDR_W'(REG_CNT_LO): reg_rdata[LO_W-1:0]      = cnt_lo;
         ADDR_W'(REG_ALM_HI): reg_rdata[HI_W-1:0]      = tgt_hi;
         ADDR_W'(REG_ALM_LO): reg_rdata[LO_W-1:0]      = tgt_lo;
         ADDR_W'(REG_PERIOD): reg_rdata[PER_W-1:0]     = per_q;
         ADDR_W'(REG_STATUS): reg_rdata[ST_ROLL:ST_PER] = st_q;
         default:             reg_rdata                = '0;
      endcase
   end

   AST_ALARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_alarm) && !$past(wr_ahi) && !$past(wr_alo))
         |-> ({cnt_hi, cnt_lo} == {tgt_hi, tgt_lo}));                     // R7
   AST_ROLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_roll) && !$past(ctrl_q.clr)) |-> ({cnt_hi, cnt_lo} == '0)); // R8
   AST_PER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.per_en && !wr_stat && !irq_period) |=> !irq_period);       // R4

endmodule

// File: tb/rtc_alarm_timer_test.sv
module rtc_alarm_timer_test;

   localparam int HI_W = 4;
   localparam int LO_W = 8;
   localparam int PER_W = 16;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 3;
   localparam int NV = 5;
   localparam logic [15:0] PTAB [NV] = '{16'd0, 16'd1, 16'd3, 16'd7, 16'd12};
   localparam int          DTAB [NV] = '{1, 2, 4, 8, 13};

   logic clk = 0;
   logic rst_n = 0;
   logic tick_en = 1;
   logic reg_wr = 0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic irq_roll, irq_alarm, irq_period;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] a, b, h;

   always #4 clk = ~clk;

   rtc_alarm_timer #(.HI_W(HI_W), .LO_W(LO_W), .PER_W(PER_W),
                     .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_roll(irq_roll), .irq_alarm(irq_alarm), .irq_period(irq_period));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // caller is at a falling edge; returns at the next falling edge
   task automatic wr(input int adr, input logic [31:0] d);
      reg_wr = 1; reg_addr = ADDR_W'(adr); reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input int adr, output logic [31:0] d);
      reg_addr = ADDR_W'(adr);
      #1;
      d = reg_rdata;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      // reset state R4
      repeat (3) @(negedge clk);
      rd(0, a); chk("R4 ctrl reset", a, 0);
      rd(2, a); chk("R4 counter lo reset", a, 0);
      rd(5, a); chk("R4 period reset", a, 0);
      rd(6, a); chk("R4 status reset", a, 0);
      chk("R4 irq reset", {29'd0, irq_roll, irq_alarm, irq_period}, 0);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // periodic table R5
      for (int i = 0; i < NV; i++) begin
         wr(0, 32'h0);
         wr(5, {16'd0, PTAB[i]});
         wr(6, 32'hE000_0000);
         wr(0, 32'h10);
         repeat (DTAB[i] - 1) @(negedge clk);
         chk($sformatf("R5 P=%0d before expiry", PTAB[i]), {31'd0, irq_period}, 0);
         @(negedge clk);
         chk($sformatf("R5 P=%0d at expiry", PTAB[i]), {31'd0, irq_period}, 1);
      end
      wr(0, 32'h0);

      // counting R1
      rd(2, a); @(negedge clk); rd(2, b);
      chk("R1 lo increments", b, (a + 1) & 32'hFF);
      for (int k = 0; k < 300; k++) begin
         rd(2, a);
         if (a == 32'hFF) break;
         @(negedge clk);
      end
      rd(1, h);
      @(negedge clk);
      rd(2, a); chk("R1 lo wraps", a, 0);
      rd(1, b); chk("R1 hi carry", b, (h + 1) & 32'hF);

      // freezes R2
      wr(0, 32'h02);
      rd(2, a); repeat (5) @(negedge clk); rd(2, b);
      chk("R2 lo frozen", b, a);
      wr(0, 32'h01);
      rd(1, a); repeat (600) @(negedge clk); rd(1, b);
      chk("R2 hi frozen", b, a);
      wr(0, 32'h0);
      wr(5, 32'd2);
      wr(6, 32'hE000_0000);
      wr(0, 32'h14);
      repeat (20) @(negedge clk);
      chk("R2 periodic frozen", {31'd0, irq_period}, 0);
      wr(0, 32'h0);

      // tick enable R10
      tick_en = 0;
      rd(2, a); repeat (5) @(negedge clk); rd(2, b);
      chk("R10 no tick holds", b, a);
      tick_en = 1;

      // clear R3
      wr(0, 32'h08);
      repeat (3) @(negedge clk);
      rd(2, a); chk("R3 lo held zero", a, 0);
      rd(1, a); chk("R3 hi held zero", a, 0);
      wr(0, 32'h0);
      rd(2, a); chk("R3 restart at 0", a, 0);
      @(negedge clk);
      rd(2, a); chk("R3 then 1", a, 1);

      // alarm R7
      wr(3, 32'hFFFF_FFF3);
      rd(3, a); chk("R7 alarm hi masked", a, 32'h3);
      wr(3, 32'h0);
      wr(4, 32'd20);
      wr(0, 32'h08);
      wr(6, 32'hE000_0000);
      wr(0, 32'h0);
      repeat (19) @(negedge clk);
      chk("R7 no alarm at 19", {31'd0, irq_alarm}, 0);
      @(negedge clk);
      chk("R7 alarm at 20", {31'd0, irq_alarm}, 1);
      rd(2, a); chk("R7 counter at target", a, 20);
      rd(6, a); chk("R9 status bit 30", a, 32'h4000_0000);
      wr(6, 32'h4000_0000);
      chk("R9 w1c clears alarm", {31'd0, irq_alarm}, 0);

      // rollover R8
      wr(0, 32'h08);
      wr(6, 32'hE000_0000);
      wr(0, 32'h0);
      repeat (4095) @(negedge clk);
      chk("R8 no roll at max", {31'd0, irq_roll}, 0);
      rd(2, a); chk("R8 lo at max", a, 32'hFF);
      @(negedge clk);
      chk("R8 roll flagged", {31'd0, irq_roll}, 1);
      rd(2, a); chk("R8 lo zero after wrap", a, 0);
      rd(1, a); chk("R8 hi zero after wrap", a, 0);
      rd(6, a); chk("R9 status bit 31", a[31], 1);

      // set beats clear R9
      wr(0, 32'h0);
      wr(5, 32'd0);
      wr(0, 32'h10);
      @(negedge clk);
      chk("R9 periodic set", {31'd0, irq_period}, 1);
      wr(6, 32'h2000_0000);
      chk("R9 event wins over clear", {31'd0, irq_period}, 1);
      wr(0, 32'h0);
      wr(6, 32'h2000_0000);
      chk("R9 clear when idle", {31'd0, irq_period}, 0);

      // reload semantics R6
      wr(5, 32'd3);
      wr(6, 32'hE000_0000);
      wr(0, 32'h10);
      wr(5, 32'd9);
      repeat (2) @(negedge clk);
      chk("R6 old period before", {31'd0, irq_period}, 0);
      @(negedge clk);
      chk("R6 old period kept", {31'd0, irq_period}, 1);
      wr(6, 32'h2000_0000);
      repeat (8) @(negedge clk);
      chk("R6 new period before", {31'd0, irq_period}, 0);
      @(negedge clk);
      chk("R6 new period used", {31'd0, irq_period}, 1);
      rd(5, a); chk("R6 period readback", a, 9);

      summary();
      $finish;
   end

endmodule